// File: doc/BRIEF.md
# Packing Serial-Port FIFO Status Unit

This block sits between a host (CPU or DMA) and the shift engine of a synchronous serial port. It holds a transmit queue, which the host fills and the shift engine drains, and a receive queue, which the shift engine fills and the host drains. Each queue has 16 entries of 32 bits. When packing is on, every entry carries two 16-bit samples. Host writes and shift-engine pushes then each add one sample. A shift-engine pull removes one sample. A host read removes up to two.

From the queue occupancies, the block builds one 32-bit status word. The word holds the fill levels, the threshold service requests, the odd-sample markers, a busy bit, and three sticky error flags. The level fields use aliased encodings. The transmit level reads 0 both when the queue is empty and when it is full. The receive level reads all ones both when the queue is empty and when it is full. Separate not-full and not-empty bits resolve these cases. Read data is presented before the strobe: the head value is on the data port, and the pull or read strobe consumes it at the next clock edge.

Serial shifting, clock generation and interrupt enabling are outside the block. They are replaced here by the strobes `frame_active`, `frame_sync` and `bit_count`.

Top module: `ssp_fifo_status`

## Requirements
- R1: After reset, both queues are empty and all flags are clear. The status word shows a transmit level of 0, transmit-not-full 1, a receive level of 4'hF and receive-not-empty 0.
- R2: Status bits 17:14 give the transmit entry count modulo 16, so a full queue reads 0. Bit 7 (transmit-not-full) is 0 only when all 16 entries are occupied. A host write to a full transmit queue is dropped and raises no flag.
- R3: Status bits 13:10 give the receive entry count minus one, modulo 16, so both empty and full read 4'hF. Bit 6 is 1 whenever any sample is held. A host read of an empty receive queue returns 0.
- R4: Bit 5, the transmit request, equals `port_en` AND (transmit entries <= `tx_thresh` + 1).
- R5: Bit 4, the receive request, equals `port_en` AND (receive entries > `rx_thresh`). With packing on, the receive entry count is the sample count divided by two, rounded up.
- R6: A shift-engine pull from an empty transmit queue returns 0 and sets the sticky underrun flag (bit 3).
- R7: A shift-engine push into a receive queue that already holds 32 samples is dropped and sets the sticky overrun flag (bit 2).
- R8: A `frame_sync` pulse while `bit_count` is nonzero sets the sticky bit-count error flag (bit 1). A pulse while `bit_count` is zero leaves the flag unchanged.
- R9: `err_clr[0]`, `err_clr[1]` and `err_clr[2]` clear the underrun, overrun and bit-count flags respectively. If a setting event and a clear hit the same flag in the same cycle, the flag ends up set.
- R10: With packing on, a host write stores bits 15:0 as one transmit sample. The sample count equals 2 x level + bit 9 (transmit odd-sample). Writes are refused once 31 samples are held, and the refusal raises no flag.
- R11: With packing on, a shift-engine push stores bits 15:0 as one receive sample. A host read returns the two oldest samples as {second, first} in bits 31:16 and 15:0. If only one sample is held, the read returns {16'h0, sample}. Bit 8 (receive odd-sample) is 1 when the receive sample count is odd.
- R12: With packing off, bits 9 and 8 read 0, and each push, pull or read moves a whole 32-bit entry.
- R13: Bit 0 (busy) equals `port_en` AND `frame_active`.
- R14: Both queues deliver data in arrival order in both modes, including across pointer wrap. With packing on, a transmit pull returns its sample in bits 15:0 with bits 31:16 zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| port_en | input | 1 | Port enable; gates requests and busy |
| pack_en | input | 1 | Two samples per entry when 1 |
| tx_thresh | input | 4 | Transmit request threshold |
| rx_thresh | input | 4 | Receive request threshold |
| host_tx_wr | input | 1 | Host write strobe into the transmit queue |
| host_tx_data | input | 32 | Host write data |
| host_rx_rd | input | 1 | Host read strobe from the receive queue |
| host_rx_data | output | 32 | Receive queue head, consumed by host_rx_rd |
| eng_tx_pull | input | 1 | Shift-engine pull strobe |
| eng_tx_sample | output | 32 | Transmit queue head, consumed by eng_tx_pull |
| eng_rx_push | input | 1 | Shift-engine push strobe |
| eng_rx_sample | input | 32 | Shift-engine push data |
| frame_active | input | 1 | A frame is being shifted |
| frame_sync | input | 1 | Frame-sync pulse |
| bit_count | input | 6 | Current shift bit counter |
| err_clr | input | 3 | Write-one-to-clear strobes for the sticky flags |
| status | output | 32 | Status word |

## Verification
Some properties are checked on every cycle. These are the aliasing of the level fields against the not-full and not-empty bits, the gating of the requests and busy by `port_en`, and the zero odd-sample bits when packing is off. Also checked every cycle: underrun, overrun and bit-count events must leave their flags set one cycle later, a clear with no competing event must drop its flag, and a packed transmit queue must hold at 31 samples. Other behaviour can only be shown by the bench's scenarios. This covers the exact level values as the queues fill, wrap and drain, the sample order and half-word placement of packed reads, and the threshold boundaries. The bench compares these against a queue model in both modes.

// File: rtl/ssp_fifo_pkg.sv
package ssp_fifo_pkg;

  localparam int FIFO_DEPTH = 16;
  localparam int SAMPLE_W   = 16;
  localparam int LVL_W      = $clog2(FIFO_DEPTH);
  localparam int STATUS_W   = 32;
  localparam int FLAG_N     = 3;
  localparam int PAD_W      = STATUS_W - 2 * LVL_W - 10;

  // Sticky flag slots, also the bit order of err_clr.
  localparam int FLG_UNDERRUN = 0;
  localparam int FLG_OVERRUN  = 1;
  localparam int FLG_BITCNT   = 2;

  typedef struct packed {
    logic [PAD_W-1:0] pad;
    logic [LVL_W-1:0] tx_level;
    logic [LVL_W-1:0] rx_level;
    logic             tx_odd;
    logic             rx_odd;
    logic             tx_not_full;
    logic             rx_not_empty;
    logic             tx_req;
    logic             rx_req;
    logic             tx_underrun;
    logic             rx_overrun;
    logic             bitcnt_err;
    logic             busy;
  } status_t;

  // Entries the transmit side reports: only complete pairs count.
  function automatic int tx_entries(int samples);
    return samples / 2;
  endfunction

  // Entries the receive side reports: a lone sample still occupies an entry.
  function automatic int rx_entries(int samples, bit packed_mode);
    if (packed_mode) return (samples + 1) / 2;
    return samples / 2;
  endfunction

  // Fold a signed value into 0 .. depth-1.
  function automatic int wrap_level(int value, int depth);
    int r;
    r = value % depth;
    if (r < 0) r = r + depth;
    return r;
  endfunction

  function automatic bit svc_low(int level, int thr);
    return level <= thr + 1;
  endfunction

  function automatic bit svc_high(int level, int thr);
    return level > thr;
  endfunction

endpackage

// File: rtl/ssp_sample_fifo.sv
module ssp_sample_fifo #(
  parameter int DEPTH    = ssp_fifo_pkg::FIFO_DEPTH,
  parameter int SAMPLE_W = ssp_fifo_pkg::SAMPLE_W,
  parameter int PACK_CAP = 2 * DEPTH,
  parameter bit POP_PAIR = 1'b0,
  parameter int SLOTS    = 2 * DEPTH,
  parameter int CW       = $clog2(SLOTS + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  pack,
  input  logic                  push,
  input  logic [2*SAMPLE_W-1:0] push_data,
  input  logic                  pop,
  output logic [2*SAMPLE_W-1:0] pop_data,
  output logic [CW-1:0]         count,
  output logic                  push_drop,
  output logic                  pop_void
);

  localparam int PW = $clog2(SLOTS);

  logic [SAMPLE_W-1:0] mem [SLOTS];
  logic [PW-1:0]       wptr, rptr;
  logic [CW-1:0]       cnt, push_amt, pop_amt, cap;
  logic                push_ok, pop_ok;
  logic [SAMPLE_W-1:0] head0, head1;
  logic                pair_out;

  always_comb begin
    push_amt  = pack ? CW'(1) : CW'(2);
    cap       = pack ? CW'(PACK_CAP) : CW'(SLOTS);
    push_ok   = push && ((cnt + push_amt) <= cap);
    push_drop = push && !push_ok;
    pop_ok    = pop && (cnt != '0);
    pop_void  = pop && (cnt == '0);
    head0     = mem[rptr];
    head1     = mem[rptr + PW'(1)];
  end

  // Pair-wide reads: unpacked always, packed only on the pairing side.
  generate
    if (POP_PAIR) begin : g_pair
      assign pair_out = !pack || (cnt >= CW'(2));
    end else begin : g_single
      assign pair_out = !pack;
    end
  endgenerate

  always_comb begin
    pop_amt = pair_out ? CW'(2) : CW'(1);
    if (cnt == '0)    pop_data = '0;
    else if (pair_out) pop_data = {head1, head0};
    else               pop_data = {{SAMPLE_W{1'b0}}, head0};
  end

  always_ff @(posedge clk) begin
    if (push_ok) begin
      mem[wptr] <= push_data[SAMPLE_W-1:0];
      if (!pack) mem[wptr + PW'(1)] <= push_data[2*SAMPLE_W-1:SAMPLE_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr <= '0;
      rptr <= '0;
      cnt  <= '0;
    end else begin
      if (push_ok) wptr <= wptr + PW'(push_amt);
      if (pop_ok)  rptr <= rptr + PW'(pop_amt);
      cnt <= cnt + (push_ok ? push_amt : '0) - (pop_ok ? pop_amt : '0);
    end
  end

  assign count = cnt;

endmodule

// File: rtl/ssp_sticky_flags.sv
module ssp_sticky_flags #(
  parameter int N = ssp_fifo_pkg::FLAG_N
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  output logic [N-1:0] q
);

  generate
    for (genvar i = 0; i < N; i++) begin : g_flag
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      q[i] <= 1'b0;
        else if (set[i]) q[i] <= 1'b1;
        else if (clr[i]) q[i] <= 1'b0;
      end
    end
  endgenerate

endmodule

// File: rtl/ssp_status_enc.sv
module ssp_status_enc
  import ssp_fifo_pkg::*;
#(
  parameter int DEPTH = FIFO_DEPTH,
  parameter int CW    = $clog2(2 * DEPTH + 1),
  parameter int THR_W = LVL_W
) (
  input  logic              pack,
  input  logic              en,
  input  logic              frame_active,
  input  logic [CW-1:0]     tx_cnt,
  input  logic [CW-1:0]     rx_cnt,
  input  logic [THR_W-1:0]  tx_thr,
  input  logic [THR_W-1:0]  rx_thr,
  input  logic [FLAG_N-1:0] flags,
  output status_t           st
);

  int tx_ent, rx_ent;

  always_comb begin
    tx_ent = tx_entries(int'(tx_cnt));
    rx_ent = rx_entries(int'(rx_cnt), pack);

    st              = '0;
    st.tx_level     = LVL_W'(wrap_level(tx_ent, DEPTH));
    st.rx_level     = LVL_W'(wrap_level(rx_ent - 1, DEPTH));
    st.tx_odd       = pack && tx_cnt[0];
    st.rx_odd       = pack && rx_cnt[0];
    st.tx_not_full  = int'(tx_cnt) != 2 * DEPTH;
    st.rx_not_empty = rx_cnt != '0;
    st.tx_req       = en && svc_low(tx_ent, int'(tx_thr));
    st.rx_req       = en && svc_high(rx_ent, int'(rx_thr));
    st.tx_underrun  = flags[FLG_UNDERRUN];
    st.rx_overrun   = flags[FLG_OVERRUN];
    st.bitcnt_err   = flags[FLG_BITCNT];
    st.busy         = en && frame_active;
  end

endmodule

// File: rtl/ssp_fifo_status.sv
module ssp_fifo_status
  import ssp_fifo_pkg::*;
#(
  parameter int DEPTH    = FIFO_DEPTH,
  parameter int SMP_W    = SAMPLE_W,
  parameter int BITCNT_W = 6,
  parameter int ENTRY_W  = 2 * SMP_W,
  parameter int THR_W    = LVL_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                port_en,
  input  logic                pack_en,
  input  logic [THR_W-1:0]    tx_thresh,
  input  logic [THR_W-1:0]    rx_thresh,
  input  logic                host_tx_wr,
  input  logic [ENTRY_W-1:0]  host_tx_data,
  input  logic                host_rx_rd,
  output logic [ENTRY_W-1:0]  host_rx_data,
  input  logic                eng_tx_pull,
  output logic [ENTRY_W-1:0]  eng_tx_sample,
  input  logic                eng_rx_push,
  input  logic [ENTRY_W-1:0]  eng_rx_sample,
  input  logic                frame_active,
  input  logic                frame_sync,
  input  logic [BITCNT_W-1:0] bit_count,
  input  logic [FLAG_N-1:0]   err_clr,
  output logic [STATUS_W-1:0] status
);

  localparam int SLOTS = 2 * DEPTH;
  localparam int CW    = $clog2(SLOTS + 1);

  logic [CW-1:0]     tx_cnt, rx_cnt;
  logic              tx_push_drop, tx_pop_void;
  logic              rx_push_drop, rx_pop_void;
  logic              tur_evt, ror_evt, bce_evt;
  logic [FLAG_N-1:0] flag_set, flag_q;
  status_t           status_q;

  ssp_sample_fifo #(
    .DEPTH(DEPTH), .SAMPLE_W(SMP_W), .PACK_CAP(SLOTS - 1), .POP_PAIR(1'b0),
    .SLOTS(SLOTS), .CW(CW)
  ) u_txq (
    .clk(clk), .rst_n(rst_n), .pack(pack_en),
    .push(host_tx_wr), .push_data(host_tx_data),
    .pop(eng_tx_pull), .pop_data(eng_tx_sample),
    .count(tx_cnt), .push_drop(tx_push_drop), .pop_void(tx_pop_void)
  );

  ssp_sample_fifo #(
    .DEPTH(DEPTH), .SAMPLE_W(SMP_W), .PACK_CAP(SLOTS), .POP_PAIR(1'b1),
    .SLOTS(SLOTS), .CW(CW)
  ) u_rxq (
    .clk(clk), .rst_n(rst_n), .pack(pack_en),
    .push(eng_rx_push), .push_data(eng_rx_sample),
    .pop(host_rx_rd), .pop_data(host_rx_data),
    .count(rx_cnt), .push_drop(rx_push_drop), .pop_void(rx_pop_void)
  );

  // Named error events, visible to the bound checker.
  assign tur_evt = tx_pop_void;
  assign ror_evt = rx_push_drop;
  assign bce_evt = frame_sync && (bit_count != '0);

  always_comb begin
    flag_set               = '0;
    flag_set[FLG_UNDERRUN] = tur_evt;
    flag_set[FLG_OVERRUN]  = ror_evt;
    flag_set[FLG_BITCNT]   = bce_evt;
  end

  ssp_sticky_flags #(.N(FLAG_N)) u_flags (
    .clk(clk), .rst_n(rst_n), .set(flag_set), .clr(err_clr), .q(flag_q)
  );

  ssp_status_enc #(.DEPTH(DEPTH), .CW(CW), .THR_W(THR_W)) u_enc (
    .pack(pack_en), .en(port_en), .frame_active(frame_active),
    .tx_cnt(tx_cnt), .rx_cnt(rx_cnt),
    .tx_thr(tx_thresh), .rx_thr(rx_thresh),
    .flags(flag_q), .st(status_q)
  );

  assign status = status_q;

endmodule

// File: rtl/ssp_fifo_status_chk.sv
module ssp_fifo_status_chk #(
  parameter int DEPTH = ssp_fifo_pkg::FIFO_DEPTH,
  parameter int CW    = $clog2(2 * DEPTH + 1),
  parameter int LW    = ssp_fifo_pkg::LVL_W
) (
  input logic          clk,
  input logic          rst_n,
  input logic          port_en,
  input logic          pack_en,
  input logic          tx_pull,
  input logic          rx_push,
  input logic          rx_pop,
  input logic          tur_evt,
  input logic          bce_evt,
  input logic          tx_push_drop,
  input logic          rx_pop_void,
  input logic [2:0]    err_clr,
  input logic [CW-1:0] tx_cnt,
  input logic [CW-1:0] rx_cnt,
  input logic [LW-1:0] tx_level,
  input logic [LW-1:0] rx_level,
  input logic          tx_odd,
  input logic          rx_odd,
  input logic          tx_nf,
  input logic          rx_ne,
  input logic          tx_req,
  input logic          rx_req,
  input logic          tur,
  input logic          ror,
  input logic          bce,
  input logic          busy
);

  p_nf_alias_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_nf |-> tx_level == '0);

  p_rx_alias_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_ne |-> &rx_level);

  p_rx_void_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rx_pop_void |-> !rx_ne);

  p_req_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !port_en |-> (!tx_req && !rx_req));

  p_underrun_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_pull && tx_cnt == '0) |=> tur);

  p_overrun_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_push && rx_cnt == CW'(2 * DEPTH) && !rx_pop) |=> (ror && rx_cnt == CW'(2 * DEPTH)));

  p_bitcnt_r8: assert property (@(posedge clk) disable iff (!rst_n)
    bce_evt |=> bce);

  p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (err_clr[0] && !tur_evt) |=> !tur);

  p_tx_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (pack_en && tx_cnt == CW'(2 * DEPTH - 1) && !tx_pull) |=> tx_cnt == CW'(2 * DEPTH - 1));

  p_tx_refuse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    tx_push_drop |-> (tx_cnt >= CW'(2 * DEPTH - 1)));

  p_odd_gate_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !pack_en |-> (!tx_odd && !rx_odd));

  p_busy_r13: assert property (@(posedge clk) disable iff (!rst_n)
    !port_en |-> !busy);

endmodule

bind ssp_fifo_status ssp_fifo_status_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .port_en(port_en), .pack_en(pack_en),
  .tx_pull(eng_tx_pull), .rx_push(eng_rx_push), .rx_pop(host_rx_rd),
  .tur_evt(tur_evt), .bce_evt(bce_evt),
  .tx_push_drop(tx_push_drop), .rx_pop_void(rx_pop_void),
  .err_clr(err_clr), .tx_cnt(tx_cnt), .rx_cnt(rx_cnt),
  .tx_level(status_q.tx_level), .rx_level(status_q.rx_level),
  .tx_odd(status_q.tx_odd), .rx_odd(status_q.rx_odd),
  .tx_nf(status_q.tx_not_full), .rx_ne(status_q.rx_not_empty),
  .tx_req(status_q.tx_req), .rx_req(status_q.rx_req),
  .tur(status_q.tx_underrun), .ror(status_q.rx_overrun),
  .bce(status_q.bitcnt_err), .busy(status_q.busy)
);

// File: tb/sim_ssp_fifo_status.sv
`timescale 1ns/1ps
module sim_ssp_fifo_status;

  localparam int PERIOD = 8;
  localparam int NV     = 15;
  // vector: [8] packing, [7:6] op (0 host write, 1 engine pull, 2 engine push, 3 host read), [5:0] repeat
  localparam logic [8:0] VEC [NV] = '{
    {1'b0, 2'd0, 6'd16}, {1'b0, 2'd0, 6'd1},  {1'b0, 2'd1, 6'd5},
    {1'b0, 2'd0, 6'd5},  {1'b0, 2'd1, 6'd17}, {1'b0, 2'd2, 6'd17},
    {1'b0, 2'd3, 6'd17},
    {1'b1, 2'd0, 6'd32}, {1'b1, 2'd1, 6'd10}, {1'b1, 2'd0, 6'd3},
    {1'b1, 2'd1, 6'd25}, {1'b1, 2'd2, 6'd33}, {1'b1, 2'd3, 6'd5},
    {1'b1, 2'd2, 6'd3},  {1'b1, 2'd3, 6'd20}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        port_en = 1'b0, pack_en = 1'b0;
  logic [3:0]  tx_thresh = 4'd3, rx_thresh = 4'd5;
  logic        host_tx_wr = 1'b0, host_rx_rd = 1'b0;
  logic [31:0] host_tx_data = '0, host_rx_data;
  logic        eng_tx_pull = 1'b0, eng_rx_push = 1'b0;
  logic [31:0] eng_tx_sample, eng_rx_sample = '0;
  logic        frame_active = 1'b0, frame_sync = 1'b0;
  logic [5:0]  bit_count = '0;
  logic [2:0]  err_clr = '0;
  logic [31:0] status;

  ssp_fifo_status u0 (
    .clk(clk), .rst_n(rst_n), .port_en(port_en), .pack_en(pack_en),
    .tx_thresh(tx_thresh), .rx_thresh(rx_thresh),
    .host_tx_wr(host_tx_wr), .host_tx_data(host_tx_data),
    .host_rx_rd(host_rx_rd), .host_rx_data(host_rx_data),
    .eng_tx_pull(eng_tx_pull), .eng_tx_sample(eng_tx_sample),
    .eng_rx_push(eng_rx_push), .eng_rx_sample(eng_rx_sample),
    .frame_active(frame_active), .frame_sync(frame_sync),
    .bit_count(bit_count), .err_clr(err_clr), .status(status)
  );

  always #(PERIOD / 2) clk = ~clk;

  int n_chk = 0, n_fail = 0, seq = 0;
  logic [31:0] tq[$], rq[$];
  bit m_pk = 0, m_en = 0, m_tur = 0, m_ror = 0, m_bce = 0, m_act = 0;
  int m_tthr = 3, m_rthr = 5;

  // Reference status word rebuilt from queue sizes.
  function automatic logic [31:0] model_word();
    int ts, rs, te, re;
    logic [31:0] w;
    ts = m_pk ? tq.size() : 2 * tq.size();
    rs = m_pk ? rq.size() : 2 * rq.size();
    te = ts / 2;
    re = m_pk ? (rs / 2 + rs % 2) : rs / 2;
    w = '0;
    w[17:14] = 4'(te & 15);
    w[13:10] = 4'((re + 15) & 15);
    w[9] = m_pk && (ts % 2 == 1);
    w[8] = m_pk && (rs % 2 == 1);
    w[7] = ts < 32;
    w[6] = rs > 0;
    w[5] = m_en && (te <= m_tthr + 1);
    w[4] = m_en && (re > m_rthr);
    w[3] = m_tur;
    w[2] = m_ror;
    w[1] = m_bce;
    w[0] = m_en && m_act;
    return w;
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic check_status(string tag);
    @(negedge clk);
    check(tag, status, model_word());
  endtask

  task automatic do_op(int op);
    logic [31:0] d, exp;
    int ts, rs;
    seq++;
    ts = m_pk ? tq.size() : 2 * tq.size();
    rs = m_pk ? rq.size() : 2 * rq.size();
    d  = m_pk ? {16'hBEEF, 16'(seq * 7 + 3)} : {16'(seq) ^ 16'hC3C3, 16'(seq)};
    @(negedge clk);
    case (op)
      0: begin
        host_tx_wr = 1'b1; host_tx_data = d;
        @(posedge clk); #1 host_tx_wr = 1'b0;
        if (m_pk ? (ts < 31) : (ts <= 30)) tq.push_back(m_pk ? {16'h0, d[15:0]} : d);
      end
      1: begin
        exp = (tq.size() == 0) ? 32'h0 : tq[0];
        eng_tx_pull = 1'b1;
        #1 check("R6 R14 tx pull data", eng_tx_sample, exp);
        @(posedge clk); #1 eng_tx_pull = 1'b0;
        if (tq.size() == 0) m_tur = 1'b1;
        else void'(tq.pop_front());
      end
      2: begin
        eng_rx_push = 1'b1; eng_rx_sample = d;
        @(posedge clk); #1 eng_rx_push = 1'b0;
        if (rs < 32) rq.push_back(m_pk ? {16'h0, d[15:0]} : d);
        else m_ror = 1'b1;
      end
      default: begin
        if (rq.size() == 0)      exp = 32'h0;
        else if (!m_pk)          exp = rq[0];
        else if (rq.size() >= 2) exp = {rq[1][15:0], rq[0][15:0]};
        else                     exp = {16'h0, rq[0][15:0]};
        host_rx_rd = 1'b1;
        #1 check("R3 R11 R14 rx read data", host_rx_data, exp);
        @(posedge clk); #1 host_rx_rd = 1'b0;
        if (rq.size() > 0) void'(rq.pop_front());
        if (m_pk && rq.size() > 0) void'(rq.pop_front());
      end
    endcase
    if (op < 2) check_status(m_pk ? "R10 R4 tx status" : "R2 R12 R4 tx status");
    else        check_status(m_pk ? "R11 R5 R7 rx status" : "R3 R12 R5 R7 rx status");
  endtask

  initial begin
    #(PERIOD * 200000);
    n_chk++; n_fail++;
    $display("FAIL R1 watchdog actual=timeout expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    check_status("R1 reset state");
    port_en = 1'b1; m_en = 1'b1;
    check_status("R1 R4 enabled empty");

    for (int i = 0; i < NV; i++) begin
      m_pk = VEC[i][8];
      pack_en = VEC[i][8];
      for (int k = 0; k < int'(VEC[i][5:0]); k++) do_op(int'(VEC[i][7:6]));
    end

    // R9: clear all, then set beats clear
    @(negedge clk); err_clr = 3'b111;
    @(posedge clk); #1 err_clr = '0;
    m_tur = 0; m_ror = 0; m_bce = 0;
    check_status("R9 clear all");
    @(negedge clk); err_clr = 3'b001; eng_tx_pull = 1'b1;
    @(posedge clk); #1 err_clr = '0; eng_tx_pull = 1'b0;
    m_tur = 1'b1;
    check_status("R9 set beats clear");

    // R8: bit-count error only with nonzero counter
    @(negedge clk); frame_sync = 1'b1; bit_count = 6'd0;
    @(posedge clk); #1 frame_sync = 1'b0;
    check_status("R8 zero counter no error");
    @(negedge clk); frame_sync = 1'b1; bit_count = 6'd9;
    @(posedge clk); #1 frame_sync = 1'b0;
    m_bce = 1'b1;
    check_status("R8 nonzero counter error");
    bit_count = 6'd0;
    check_status("R8 error sticky");

    // R13: busy, and gating by port enable
    frame_active = 1'b1; m_act = 1'b1;
    check_status("R13 busy");
    port_en = 1'b0; m_en = 1'b0;
    check_status("R13 R4 R5 disabled");
    port_en = 1'b1; m_en = 1'b1; frame_active = 1'b0; m_act = 1'b0;

    // R4/R5: threshold boundaries, unpacked
    m_pk = 0; pack_en = 1'b0;
    tx_thresh = 4'd2; m_tthr = 2;
    rx_thresh = 4'd1; m_rthr = 1;
    for (int k = 0; k < 5; k++) do_op(0);
    for (int k = 0; k < 4; k++) do_op(2);
    for (int k = 0; k < 5; k++) do_op(1);
    for (int k = 0; k < 4; k++) do_op(3);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule